// File: doc/BRIEF.md
# Dual Timer/Counter Unit

This block holds two 16-bit timer/counters, each made of a low byte and a high byte, in the style of a classic 8-bit microcontroller peripheral. A shared 8-bit mode register chooses, for each timer, whether an external gate pin takes part, whether the timer counts internal machine cycles or falling edges on an external pin, and one of four operating modes. The modes are a 13-bit prescaled count, a 16-bit cascaded count, an 8-bit count that reloads itself from the high byte, and a split mode. In split mode timer 0 becomes two independent 8-bit counters and timer 1 lends its run bit and its overflow flag to the second of them.

Software uses a small byte-wide register port to configure the unit, start and stop the timers, preload or read the count bytes, and clear the overflow flags. A machine cycle is twelve core clocks and is produced inside the block. The external count pins and gate pins are asynchronous and pass through two-flop synchronizers. Each count pin feeds its own edge detector state machine with three states. EDG_LOW means the last sample was low. EDG_HIGH means the last sample was high. EDG_FALL is a one-clock pending state. The detector moves from EDG_LOW to EDG_HIGH when a machine-cycle sample is high. It moves from EDG_HIGH to EDG_FALL when a sample is low. It always returns from EDG_FALL to EDG_LOW on the next clock, and in that clock the counter advances.

Top module: `dual_tmr_unit`

## Requirements
- R1: After reset the mode register, the run bits, the overflow flags and all four count bytes are zero. The machine-cycle phase also starts at zero, so the first machine-cycle tick comes on the 12th rising clock edge after reset is released.
- R2: In timer function an enabled timer advances exactly once per machine cycle, on the clock edge that ends each group of 12 core clocks.
- R3: Register map by address. Address 0 is the mode register. Address 1 is control: bit 0 run0, bit 1 run1, bit 2 overflow0, bit 3 overflow1, other bits read 0. Address 2 is timer 0 low, 3 is timer 0 high, 4 is timer 1 low and 5 is timer 1 high. Addresses 6 and 7 read 0. In the mode register, bits 3..0 configure timer 0 and bits 7..4 configure timer 1, each nibble ordered {gate, external, mode[1], mode[0]}.
- R4: Mode 00 counts in 13 bits. Low-byte bits 4..0 form a prescaler that carries into the high byte, low-byte bits 7..5 are left unchanged, and the timer overflows when all 13 bits roll over from ones to zero.
- R5: Mode 01 cascades the high and low bytes into a 16-bit counter that overflows from FFFFh to 0000h.
- R6: Mode 10 counts in the low byte only. When the low byte advances past FFh it takes the value of the high byte and the timer overflows.
- R7: With the gate bit set, a timer advances only while its synchronized gate pin is high and its run bit is 1. With the gate bit clear, only the run bit is needed.
- R8: An overflow sets that timer's flag, which stays set until software writes the control register. The flags drive the ovf_flag outputs.
- R9: With the external bit set, a timer advances once for each machine-cycle sample pair of its synchronized count pin that reads high and then low. The advance lands on the clock after the detecting tick, and a level held for 12 or more clocks is always sampled.
- R10: In timer 0 mode 11, the timer 0 low byte is an 8-bit counter under timer 0's controls and sets overflow0. The timer 0 high byte counts machine cycles while run1 is 1, ignores gate and count pins, and its rollover sets overflow1. Timer 1's own rollovers then leave overflow1 untouched.
- R11: A register write to a count byte beats an advance in the same clock. That timer does not advance or overflow in that clock, except that in split mode each byte of timer 0 is cancelled only by a write to itself. An overflow beats a software clear of the flag in the same clock.
- R12: Timer 1 in mode 11 holds its count bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| cnt_pin | input | 2 | External count pins, bit n for timer n, asynchronous |
| gate_pin | input | 2 | External gate pins, bit n for timer n, asynchronous |
| ovf_flag | output | 2 | Overflow flags, bit n for timer n |

## Verification
A wrong phase count or a stuck edge-detector state shows up first as a count byte that is one step early or late. The reference model compares reg_rdata and ovf_flag every clock, so the mismatch is caught at the first machine-cycle tick after the fault, at most 12 clocks later. Faults in mode decoding, carry between the bytes or reload first change the low byte at a tick. They reach ovf_flag only at the next rollover, which the bench brings close by preloading counts near their limit. Split-mode and write-priority faults show up in the same clock as the tick or write that triggers them.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Operating mode of one timer, encoded as {m1, m0}
    typedef enum logic [1:0] {
        MODE_PRE13   = 2'b00,
        MODE_CAS16   = 2'b01,
        MODE_RELOAD8 = 2'b10,
        MODE_SPLIT   = 2'b11
    } tmr_mode_e;

    // One nibble of the mode register
    typedef struct packed {
        logic      gate;
        logic      ext;
        tmr_mode_e mode;
    } tmr_cfg_t;

    // Count-pin edge detector states
    typedef enum logic [1:0] {
        EDG_LOW  = 2'd0,
        EDG_HIGH = 2'd1,
        EDG_FALL = 2'd2
    } edg_state_e;

    localparam int ADR_MODE  = 0;
    localparam int ADR_CTRL  = 1;
    localparam int ADR_T0_LO = 2;
    localparam int ADR_T0_HI = 3;
    localparam int ADR_T1_LO = 4;
    localparam int ADR_T1_HI = 5;

    localparam int CTL_RUN0 = 0;
    localparam int CTL_RUN1 = 1;
    localparam int CTL_OVF0 = 2;
    localparam int CTL_OVF1 = 3;

    localparam int NUM_TMR = 2;

endpackage

// File: rtl/tmr_phase.sv
module tmr_phase #(
    parameter int CYCLE_LEN = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PH_W = (CYCLE_LEN > 1) ? $clog2(CYCLE_LEN) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYCLE_LEN - 1);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (phase_q == PH_LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PH_W'(1);
        end
    end

    assign tick = (phase_q == PH_LAST);

endmodule

// File: rtl/tmr_sync2.sv
module tmr_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= 2'b00;
        end else begin
            stage_q <= {stage_q[0], d_async};
        end
    end

    assign q_sync = stage_q[1];

endmodule

// File: rtl/tmr_edge.sv
module tmr_edge
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin_async,
    output logic fall_pend
);
    logic       pin_s;
    edg_state_e st_q;
    edg_state_e st_n;

    tmr_sync2 u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_async),
        .q_sync  (pin_s)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= EDG_LOW;
        end else begin
            st_q <= st_n;
        end
    end

    // Transitions: samples are only taken on the machine-cycle tick
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            EDG_LOW: begin
                if (tick && pin_s) begin
                    st_n = EDG_HIGH;
                end
            end
            EDG_HIGH: begin
                if (tick && !pin_s) begin
                    st_n = EDG_FALL;
                end
            end
            EDG_FALL: begin
                st_n = EDG_LOW;
            end
            default: begin
                st_n = EDG_LOW;
            end
        endcase
    end

    // Output: one-clock pending pulse
    always_comb begin
        fall_pend = (st_q == EDG_FALL);
    end

endmodule

// File: rtl/tmr_count.sv
module tmr_count
    import tmr_pkg::*;
#(
    parameter bit SPLIT_OK = 1'b0,
    parameter int BYTE_W   = 8,
    parameter int PRE_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_mode_e         mode,
    input  logic              step_lo,
    input  logic              step_hi,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] lo_q,
    output logic [BYTE_W-1:0] hi_q,
    output logic              ovf_main,
    output logic              ovf_aux
);
    localparam int WIDE_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] lo_n;
    logic [BYTE_W-1:0] hi_n;
    logic [WIDE_W-1:0] wide_n;
    logic              any_wr;

    assign any_wr = wr_lo | wr_hi;

    always_comb begin
        lo_n     = lo_q;
        hi_n     = hi_q;
        wide_n   = {hi_q, lo_q} + WIDE_W'(1);
        ovf_main = 1'b0;
        ovf_aux  = 1'b0;
        unique case (mode)
            MODE_PRE13: begin
                if (step_lo && !any_wr) begin
                    lo_n[PRE_W-1:0] = lo_q[PRE_W-1:0] + PRE_W'(1);
                    if (&lo_q[PRE_W-1:0]) begin
                        hi_n     = hi_q + BYTE_W'(1);
                        ovf_main = &hi_q;
                    end
                end
            end
            MODE_CAS16: begin
                if (step_lo && !any_wr) begin
                    {hi_n, lo_n} = wide_n;
                    ovf_main     = &{hi_q, lo_q};
                end
            end
            MODE_RELOAD8: begin
                if (step_lo && !any_wr) begin
                    if (&lo_q) begin
                        lo_n     = hi_q;
                        ovf_main = 1'b1;
                    end else begin
                        lo_n = lo_q + BYTE_W'(1);
                    end
                end
            end
            MODE_SPLIT: begin
                if (SPLIT_OK) begin
                    if (step_lo && !wr_lo) begin
                        lo_n     = lo_q + BYTE_W'(1);
                        ovf_main = &lo_q;
                    end
                    if (step_hi && !wr_hi) begin
                        hi_n    = hi_q + BYTE_W'(1);
                        ovf_aux = &hi_q;
                    end
                end
            end
            default: begin
                lo_n = lo_q;
            end
        endcase
        if (wr_lo) begin
            lo_n = wdata;
        end
        if (wr_hi) begin
            hi_n = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

endmodule

// File: rtl/dual_tmr_unit.sv
module dual_tmr_unit
    import tmr_pkg::*;
#(
    parameter int CYCLE_LEN = 12,
    parameter int BYTE_W    = 8,
    parameter int ADDR_W    = 3,
    parameter int PRE_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic [1:0]        cnt_pin,
    input  logic [1:0]        gate_pin,
    output logic [1:0]        ovf_flag
);
    localparam int NIB_W = 4;

    logic              tick;
    logic [BYTE_W-1:0] mode_q;
    logic [1:0]        run_q;
    logic [1:0]        ovf_q;
    tmr_cfg_t          cfg      [NUM_TMR];
    logic [1:0]        gate_s;
    logic [1:0]        fall;
    logic [1:0]        enable;
    logic [1:0]        step;
    logic [1:0]        step_hi;
    logic [1:0]        wr_lo;
    logic [1:0]        wr_hi;
    logic [BYTE_W-1:0] lo_v     [NUM_TMR];
    logic [BYTE_W-1:0] hi_v     [NUM_TMR];
    logic [1:0]        ovf_main;
    logic [1:0]        ovf_aux;
    logic [1:0]        ovf_set;
    logic              split0;
    logic              wr_mode;
    logic              wr_ctrl;

    tmr_phase #(.CYCLE_LEN(CYCLE_LEN)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    assign wr_mode = reg_wr && (reg_addr == ADDR_W'(ADR_MODE));
    assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(ADR_CTRL));
    assign wr_lo[0] = reg_wr && (reg_addr == ADDR_W'(ADR_T0_LO));
    assign wr_hi[0] = reg_wr && (reg_addr == ADDR_W'(ADR_T0_HI));
    assign wr_lo[1] = reg_wr && (reg_addr == ADDR_W'(ADR_T1_LO));
    assign wr_hi[1] = reg_wr && (reg_addr == ADDR_W'(ADR_T1_HI));

    assign split0 = (cfg[0].mode == MODE_SPLIT);

    // Timer 0 high byte in split mode: machine cycles, gated by run1 only
    assign step_hi[0] = tick & run_q[CTL_RUN1];
    assign step_hi[1] = 1'b0;

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        assign cfg[g] = tmr_cfg_t'(mode_q[g*NIB_W +: NIB_W]);

        tmr_sync2 u_gate_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_async (gate_pin[g]),
            .q_sync  (gate_s[g])
        );

        tmr_edge u_edge (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .pin_async (cnt_pin[g]),
            .fall_pend (fall[g])
        );

        assign enable[g] = run_q[g] & (~cfg[g].gate | gate_s[g]);
        assign step[g]   = enable[g] & (cfg[g].ext ? fall[g] : tick);

        tmr_count #(
            .SPLIT_OK (g == 0),
            .BYTE_W   (BYTE_W),
            .PRE_W    (PRE_W)
        ) u_count (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (cfg[g].mode),
            .step_lo  (step[g]),
            .step_hi  (step_hi[g]),
            .wr_lo    (wr_lo[g]),
            .wr_hi    (wr_hi[g]),
            .wdata    (reg_wdata),
            .lo_q     (lo_v[g]),
            .hi_q     (hi_v[g]),
            .ovf_main (ovf_main[g]),
            .ovf_aux  (ovf_aux[g])
        );
    end

    // Overflow sources: timer 0 split high byte takes over flag 1
    assign ovf_set[0] = ovf_main[0];
    assign ovf_set[1] = split0 ? ovf_aux[0] : ovf_main[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_mode) begin
            mode_q <= reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 2'b00;
            ovf_q <= 2'b00;
        end else if (wr_ctrl) begin
            run_q <= {reg_wdata[CTL_RUN1], reg_wdata[CTL_RUN0]};
            ovf_q <= {reg_wdata[CTL_OVF1], reg_wdata[CTL_OVF0]} | ovf_set;
        end else begin
            ovf_q <= ovf_q | ovf_set;
        end
    end

    assign ovf_flag = ovf_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(ADR_MODE): reg_rdata = mode_q;
            ADDR_W'(ADR_CTRL): begin
                reg_rdata[CTL_RUN0] = run_q[0];
                reg_rdata[CTL_RUN1] = run_q[1];
                reg_rdata[CTL_OVF0] = ovf_q[0];
                reg_rdata[CTL_OVF1] = ovf_q[1];
            end
            ADDR_W'(ADR_T0_LO): reg_rdata = lo_v[0];
            ADDR_W'(ADR_T0_HI): reg_rdata = hi_v[0];
            ADDR_W'(ADR_T1_LO): reg_rdata = lo_v[1];
            ADDR_W'(ADR_T1_HI): reg_rdata = hi_v[1];
            default:            reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int CYCLE_LEN = 12,
    parameter int BYTE_W    = 8,
    parameter int ADDR_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [BYTE_W-1:0] reg_wdata,
    input logic [BYTE_W-1:0] mode_q,
    input logic [1:0]        run_q,
    input logic              step0,
    input logic [BYTE_W-1:0] lo0,
    input logic [BYTE_W-1:0] hi0,
    input logic [BYTE_W-1:0] lo1,
    input logic [BYTE_W-1:0] hi1,
    input logic [1:0]        ovf_set,
    input logic [1:0]        ovf_flag
);
    int gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap <= 0;
        end else if (tick) begin
            gap <= 0;
        end else begin
            gap <= gap + 1;
        end
    end

    logic wr_t0;
    logic wr_t1;
    assign wr_t0 = reg_wr && (reg_addr == ADDR_W'(2) || reg_addr == ADDR_W'(3));
    assign wr_t1 = reg_wr && (reg_addr == ADDR_W'(4) || reg_addr == ADDR_W'(5));

    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap == CYCLE_LEN - 1));

    assert_lo_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(2)) |=> (lo0 == $past(reg_wdata)));

    assert_reload_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1:0] == 2'b10 && step0 && (&lo0) && !wr_t0) |=> (lo0 == $past(hi0)));

    assert_flag0_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set[0] |=> ovf_flag[0]);

    assert_flag1_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set[1] |=> ovf_flag[1]);

    assert_t1_stopped_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[5:4] == 2'b11 && !wr_t1) |=> ($stable(lo1) && $stable(hi1)));

    assert_split_hi_run1_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1:0] == 2'b11 && !run_q[1] && !(reg_wr && reg_addr == ADDR_W'(3)))
        |=> $stable(hi0));

endmodule

bind dual_tmr_unit tmr_chk #(
    .CYCLE_LEN (CYCLE_LEN),
    .BYTE_W    (BYTE_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mode_q    (mode_q),
    .run_q     (run_q),
    .step0     (step[0]),
    .lo0       (lo_v[0]),
    .hi0       (hi_v[0]),
    .lo1       (lo_v[1]),
    .hi1       (hi_v[1]),
    .ovf_set   (ovf_set),
    .ovf_flag  (ovf_flag)
);

// File: tb/dual_tmr_unit_tb.sv
`timescale 1ns/1ps
module dual_tmr_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [1:0] cnt_pin = 2'b00;
    logic [1:0] gate_pin = 2'b00;
    logic [1:0] ovf_flag;

    always #2.5 clk = ~clk;

    dual_tmr_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cnt_pin   (cnt_pin),
        .gate_pin  (gate_pin),
        .ovf_flag  (ovf_flag)
    );

    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // ---------------- behavioural reference model ----------------
    int       ph;
    bit [7:0] m_mode;
    bit [1:0] m_run, m_ovf;
    bit [7:0] m_lo [2];
    bit [7:0] m_hi [2];
    bit [1:0] c_s1, c_s2, g_s1, g_s2;
    bit [1:0] m_last, m_pend;

    task automatic adv(input int md, input bit [7:0] lo, input bit [7:0] hi,
                       output bit [7:0] nlo, output bit [7:0] nhi, output bit ov);
        int tot;
        nlo = lo; nhi = hi; ov = 1'b0;
        case (md)
            0: begin
                tot = int'(hi) * 32 + int'(lo % 32) + 1;
                if (tot == 8192) begin ov = 1'b1; tot = 0; end
                nhi = 8'(tot / 32);
                nlo = (lo & 8'hE0) | 8'(tot % 32);
            end
            1: begin
                tot = int'(hi) * 256 + int'(lo) + 1;
                if (tot == 65536) begin ov = 1'b1; tot = 0; end
                nhi = 8'(tot / 256);
                nlo = 8'(tot % 256);
            end
            2: begin
                if (lo == 8'hFF) begin nlo = hi; ov = 1'b1; end
                else nlo = lo + 8'd1;
            end
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; m_mode = 0; m_run = 0; m_ovf = 0;
            m_lo[0] = 0; m_lo[1] = 0; m_hi[0] = 0; m_hi[1] = 0;
            c_s1 = 0; c_s2 = 0; g_s1 = 0; g_s2 = 0; m_last = 0; m_pend = 0;
        end else begin
            bit tick;
            bit [1:0] stp, setf;
            bit [7:0] nlo [2];
            bit [7:0] nhi [2];
            bit ov;
            int md0, md1;
            tick = (ph == 11);
            setf = 2'b00;
            md0 = int'(m_mode[1:0]);
            md1 = int'(m_mode[5:4]);
            for (int t = 0; t < 2; t++) begin
                bit en;
                en = m_run[t] && (!m_mode[4*t+3] || g_s2[t]);
                stp[t] = en && (m_mode[4*t+2] ? m_pend[t] : tick);
                nlo[t] = m_lo[t];
                nhi[t] = m_hi[t];
            end
            // timer 0
            if (md0 == 3) begin
                if (stp[0] && !(reg_wr && reg_addr == 2)) begin
                    nlo[0] = m_lo[0] + 8'd1;
                    if (m_lo[0] == 8'hFF) setf[0] = 1'b1;
                end
                if (tick && m_run[1] && !(reg_wr && reg_addr == 3)) begin
                    nhi[0] = m_hi[0] + 8'd1;
                    if (m_hi[0] == 8'hFF) setf[1] = 1'b1;
                end
            end else if (stp[0] && !(reg_wr && (reg_addr == 2 || reg_addr == 3))) begin
                adv(md0, m_lo[0], m_hi[0], nlo[0], nhi[0], ov);
                if (ov) setf[0] = 1'b1;
            end
            // timer 1
            if (md1 != 3 && stp[1] && !(reg_wr && (reg_addr == 4 || reg_addr == 5))) begin
                adv(md1, m_lo[1], m_hi[1], nlo[1], nhi[1], ov);
                if (ov && md0 != 3) setf[1] = 1'b1;
            end
            if (reg_wr) begin
                case (int'(reg_addr))
                    0: m_mode = reg_wdata;
                    2: nlo[0] = reg_wdata;
                    3: nhi[0] = reg_wdata;
                    4: nlo[1] = reg_wdata;
                    5: nhi[1] = reg_wdata;
                    default: ;
                endcase
            end
            if (reg_wr && reg_addr == 1) begin
                m_run = reg_wdata[1:0];
                m_ovf = reg_wdata[3:2] | setf;
            end else begin
                m_ovf = m_ovf | setf;
            end
            for (int t = 0; t < 2; t++) begin
                m_lo[t] = nlo[t];
                m_hi[t] = nhi[t];
                if (tick) begin
                    m_pend[t] = m_last[t] && !c_s2[t];
                    m_last[t] = c_s2[t];
                end else begin
                    m_pend[t] = 1'b0;
                end
            end
            c_s2 = c_s1; c_s1 = cnt_pin;
            g_s2 = g_s1; g_s1 = gate_pin;
            ph = (ph == 11) ? 0 : ph + 1;
        end
    end

    function automatic bit [7:0] exp_rd(input bit [2:0] a);
        case (int'(a))
            0: return m_mode;
            1: return {4'b0, m_ovf[1], m_ovf[0], m_run[1], m_run[0]};
            2: return m_lo[0];
            3: return m_hi[0];
            4: return m_lo[1];
            5: return m_hi[1];
            default: return 8'h00;
        endcase
    endfunction

    // ---------------- stimulus helpers ----------------
    task automatic cyc();
        @(negedge clk);
        n_chk++;
        if (reg_rdata !== exp_rd(reg_addr) || ovf_flag !== m_ovf) begin
            n_err++;
            $display("FAIL %s addr %0d rdata %h exp %h ovf %b exp %b", cur_req,
                     reg_addr, reg_rdata, exp_rd(reg_addr), ovf_flag, m_ovf);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input bit [2:0] a, input bit [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic look(input bit [2:0] a);
        reg_addr = a;
        cyc();
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int keep;
        run(3);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: everything reads zero after reset
        cur_req = "R1";
        for (int a = 0; a < 8; a++) begin
            look(3'(a));
            chk("R1", int'(reg_rdata), 0);
        end
        chk("R1", int'(ovf_flag), 0);

        // R3 / R5 / R2: timer 0 16-bit timer near rollover
        cur_req = "R5";
        wr(0, 8'h01);
        wr(2, 8'hFD);
        wr(3, 8'hFF);
        wr(1, 8'h01);
        look(2);
        run(60);
        chk("R5", int'(ovf_flag[0]), 1);
        cur_req = "R3";
        look(0);
        chk("R3", int'(reg_rdata), 8'h01);

        // R8: software clear of overflow
        cur_req = "R8";
        wr(1, 8'h01);
        chk("R8", int'(ovf_flag[0]), 0);
        look(1);
        run(20);

        // R4: 13-bit mode, upper low-byte bits kept
        cur_req = "R4";
        wr(1, 8'h00);
        wr(0, 8'h00);
        wr(2, 8'hFC);
        wr(3, 8'hFF);
        wr(1, 8'h01);
        look(2);
        run(70);
        look(3);
        run(10);
        chk("R4", int'(ovf_flag[0]), 1);

        // R6: auto-reload
        cur_req = "R6";
        wr(1, 8'h00);
        wr(0, 8'h02);
        wr(3, 8'hFC);
        wr(2, 8'hFD);
        wr(1, 8'h01);
        look(2);
        run(100);

        // R7: gating
        cur_req = "R7";
        wr(1, 8'h00);
        wr(0, 8'h09);
        gate_pin = 2'b00;
        wr(2, 8'h00);
        wr(3, 8'h00);
        wr(1, 8'h01);
        look(2);
        run(60);
        chk("R7", int'(reg_rdata), 0);
        gate_pin = 2'b01;
        run(50);
        gate_pin = 2'b00;
        run(30);

        // R9: external count on both timers
        cur_req = "R9";
        wr(1, 8'h00);
        wr(0, 8'h55);
        wr(2, 8'h00); wr(3, 8'h00); wr(4, 8'h00); wr(5, 8'h00);
        wr(1, 8'h03);
        look(2);
        for (int k = 0; k < 5; k++) begin
            cnt_pin = 2'b11; run(24);
            cnt_pin = 2'b00; run(24);
        end
        run(30);
        look(2);
        chk("R9", int'(reg_rdata), 5);
        look(4);
        chk("R9", int'(reg_rdata), 5);
        for (int k = 0; k < 12; k++) begin
            cnt_pin = 2'b01; run(3);
            cnt_pin = 2'b10; run(4);
        end
        cnt_pin = 2'b00;
        run(30);

        // R10: split mode on timer 0, timer 1 overflow suppressed
        cur_req = "R10";
        wr(1, 8'h00);
        wr(0, 8'h03);
        wr(2, 8'hF0); wr(3, 8'hFE);
        wr(4, 8'h1F); wr(5, 8'hFF);
        wr(1, 8'h03);
        look(3);
        run(40);
        chk("R10", int'(ovf_flag[1]), 1);
        wr(1, 8'h02);
        look(2);
        run(30);
        look(3);
        run(30);
        wr(1, 8'h01);
        run(30);

        // R12: timer 1 stopped in mode 11
        cur_req = "R12";
        wr(1, 8'h00);
        wr(0, 8'h30);
        wr(4, 8'h42);
        wr(1, 8'h02);
        look(4);
        keep = int'(reg_rdata);
        run(40);
        chk("R12", int'(reg_rdata), keep);

        // R11: writes racing increments and flag sets
        cur_req = "R11";
        wr(1, 8'h00);
        wr(0, 8'h01);
        wr(3, 8'h10);
        wr(1, 8'h01);
        for (int i = 0; i < 14; i++) wr(2, 8'(8'h80 + i));
        look(2);
        run(15);
        wr(1, 8'h00);
        wr(0, 8'h02);
        wr(3, 8'hFF);
        wr(2, 8'hFF);
        wr(1, 8'h01);
        for (int i = 0; i < 24; i++) wr(1, 8'h01);
        look(1);
        run(14);
        chk("R11", int'(ovf_flag[0]), 1);

        // R2: plain timer pace check through the model
        cur_req = "R2";
        wr(1, 8'h00);
        wr(0, 8'h11);
        wr(2, 8'h00); wr(3, 8'h00); wr(4, 8'h00); wr(5, 8'h00);
        wr(1, 8'h03);
        look(2);
        run(120);
        chk("R2", int'(reg_rdata) >= 9 ? 1 : 0, 1);

        finish_run();
    end

endmodule